// File: doc/BRIEF.md
# Masked Port Event Interrupt Controller

This block gathers event flags for four power ports and one device-wide fault source into clear-on-read registers. It filters them through a shared event mask and condenses the result into an interrupt summary register and an active-low interrupt pin. Event pulses arrive from the port monitors. A host reaches the registers through a simple synchronous read/write port with a read strobe.

An external agent, such as alert response logic on the serial bus, can release the pin with a one-cycle release request. After that, the pin stays high until every pending summary source has been cleared by reads. Only then can new events pull it low again.

Register map (8-bit data, 5-bit address): 0x00 summary (read only), 0x01 event mask (read/write), 0x02 to 0x05 event flags of ports 0 to 3 (clear on read), 0x1D device event flags (clear on read).

Top module: `port_evt_irq`

## Requirements
- R1: `int_n` is low exactly when the summary register is non-zero and no release is in force; otherwise it is high.
- R2: Summary register 0x00 has bit p (p = 0..3) set when port p has any flag whose mask bit is set, bit 7 set when any device flag is set, and bits 6:4 at zero.
- R3: A pulse on `evt_i[p*6+k]` sets bit k of port p's flag register on the next clock edge, and the bit stays set until cleared. The bit order is: 0 start-up overcurrent, 1 running overcurrent cut, 2 classification done, 3 detection, 4 power-good change, 5 power-enable change.
- R4: Mask register 0x01 holds bits 5:0, one per event type in the R3 order. It is written by `reg_wr`, resets to zero and reads bits 7:6 as zero.
- R5: A read strobe to 0x02+p returns port p's flags in bits 5:0 and clears that register on the same edge.
- R6: An event pulse in the same cycle as a clearing read of its register is kept set after that edge. The read data does not include it.
- R7: A `rel_i` pulse while the summary is non-zero drives `int_n` high from the next edge on. It stays high, even if new events arrive, until the summary has been zero for one edge.
- R8: Device register 0x1D has bit 0 set by `sup_flt_i` (supply out of range) and bit 1 set by `tmp_flt_i` (temperature). It is clear on read with the R6 priority, and its mask does not apply.
- R9: `reg_rdata` is loaded on the edge that samples `reg_rd` and holds otherwise. Unmapped addresses read zero, and writes to any address other than 0x01 change nothing.
- R10: After reset all flags, the mask, the release state and `reg_rdata` are zero, and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Event pulses, port p at bits p*6+5..p*6 |
| sup_flt_i | input | 1 | Supply out-of-range pulse |
| tmp_flt_i | input | 1 | Temperature event pulse |
| rel_i | input | 1 | Interrupt release request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bound checker checks the following on every cycle:
- event capture and flag persistence;
- clear-on-read with event-beats-clear priority;
- mask writes;
- that a low `int_n` is always backed by a masked port flag or a device flag;
- that `int_n` is high whenever a release is in force.

Only the bench scenarios can show the full release sequence. In that sequence a release holds the pin through new events, the clearing reads empty the summary, and a later event pulls the pin low again. The scenarios are also needed to show that the summary bit layout and unmapped-address behaviour match the register map.

// File: rtl/port_evt_irq.sv
module port_evt_irq #(
  parameter int NPORT     = 4,
  parameter int NEVT      = 6,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int ADDR_SUM  = 0,
  parameter int ADDR_MASK = 1,
  parameter int ADDR_EVT0 = 2,
  parameter int ADDR_DEV  = 29
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT*NEVT-1:0] evt_i,
  input  logic                  sup_flt_i,
  input  logic                  tmp_flt_i,
  input  logic                  rel_i,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  int_n
);
  localparam int FLAT = NPORT * NEVT;

  logic [FLAT-1:0]  evt_q;
  logic [NEVT-1:0]  mask_q;
  logic [1:0]       dev_q;
  logic             released_q;
  logic [NPORT-1:0] port_hit;
  logic [NPORT-1:0] rd_port;
  logic [DW-1:0]    summary;
  logic [DW-1:0]    rd_mux;
  logic             rd_dev;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_hit[p] = |(evt_q[p*NEVT +: NEVT] & mask_q);
    assign rd_port[p]  = reg_rd && (reg_addr == AW'(ADDR_EVT0 + p));
  end

  assign rd_dev = reg_rd && (reg_addr == AW'(ADDR_DEV));

  always_comb begin
    summary = '0;
    summary[NPORT-1:0] = port_hit;
    summary[DW-1] = |dev_q;
  end

  assign int_n = ~(|summary & ~released_q);

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(ADDR_SUM))       rd_mux = summary;
    else if (reg_addr == AW'(ADDR_MASK)) rd_mux[NEVT-1:0] = mask_q;
    else if (reg_addr == AW'(ADDR_DEV))  rd_mux[1:0] = dev_q;
    else
      for (int p = 0; p < NPORT; p++)
        if (reg_addr == AW'(ADDR_EVT0 + p)) rd_mux[NEVT-1:0] = evt_q[p*NEVT +: NEVT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q      <= '0;
      mask_q     <= '0;
      dev_q      <= '0;
      released_q <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        evt_q[p*NEVT +: NEVT] <= (rd_port[p] ? '0 : evt_q[p*NEVT +: NEVT])
                                 | evt_i[p*NEVT +: NEVT];
      dev_q      <= (rd_dev ? 2'b00 : dev_q) | {tmp_flt_i, sup_flt_i};
      released_q <= |summary & (released_q | rel_i);
      if (reg_wr && reg_addr == AW'(ADDR_MASK)) mask_q <= reg_wdata[NEVT-1:0];
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/port_evt_irq_chk.sv
module port_evt_irq_chk #(
  parameter int NPORT     = 4,
  parameter int NEVT      = 6,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int ADDR_MASK = 1,
  parameter int ADDR_EVT0 = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPORT*NEVT-1:0] evt_i,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [AW-1:0]         reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic                  int_n,
  input logic [NPORT*NEVT-1:0] evt_q,
  input logic [NEVT-1:0]       mask_q,
  input logic [1:0]            dev_q,
  input logic                  released_q
);
  logic [NPORT*NEVT-1:0] mask_all;
  always_comb
    for (int p = 0; p < NPORT; p++) mask_all[p*NEVT +: NEVT] = mask_q;

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> ((evt_q & $past(evt_i)) == $past(evt_i))); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && evt_q[NEVT-1:0] != '0) |=> ((evt_q[NEVT-1:0] & $past(evt_q[NEVT-1:0])) == $past(evt_q[NEVT-1:0]))); // R3

  AST_PORT0_COR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(ADDR_EVT0)) |=> (evt_q[NEVT-1:0] == $past(evt_i[NEVT-1:0]))); // R5

  AST_EVT_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(ADDR_EVT0) && evt_i[NEVT-1:0] != '0) |=> (evt_q[NEVT-1:0] != '0)); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(ADDR_MASK)) |=> (mask_q == $past(reg_wdata[NEVT-1:0]))); // R4

  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (((evt_q & mask_all) != '0) || dev_q != 2'b00)); // R1

  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    released_q |-> int_n); // R7
endmodule

bind port_evt_irq port_evt_irq_chk #(
  .NPORT(NPORT), .NEVT(NEVT), .AW(AW), .DW(DW),
  .ADDR_MASK(ADDR_MASK), .ADDR_EVT0(ADDR_EVT0)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_n(int_n), .evt_q(evt_q),
  .mask_q(mask_q), .dev_q(dev_q), .released_q(released_q)
);

// File: tb/tb_port_evt_irq.sv
module tb_port_evt_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_i = '0;
  logic        sup_flt_i = 1'b0, tmp_flt_i = 1'b0, rel_i = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        int_n;

  always #2 clk = ~clk;

  port_evt_irq dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0] m_ev [4];
  logic [5:0] m_mask;
  logic [1:0] m_dev;
  logic       m_rel;
  logic [7:0] exp_rd;
  logic [4:0] last_addr;

  function automatic logic [7:0] summ();
    logic [7:0] s = '0;
    for (int p = 0; p < 4; p++) s[p] = |(m_ev[p] & m_mask);
    s[7] = |m_dev;
    return s;
  endfunction

  function automatic logic [7:0] rd_val(input logic [4:0] a);
    if (a == 5'h00) return summ();
    if (a == 5'h01) return {2'b00, m_mask};
    if (a == 5'h1D) return {6'b0, m_dev};
    if (a >= 5'h02 && a <= 5'h05) return {2'b00, m_ev[a-2]};
    return 8'h00;
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    if (a == 5'h00) return "R2";
    if (a == 5'h01) return "R4";
    if (a == 5'h1D) return "R8";
    if (a >= 5'h02 && a <= 5'h05) return "R5";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] ev, input logic sup, input logic tmp,
                      input logic rel, input logic rd, input logic wr,
                      input logic [4:0] a, input logic [7:0] wd);
    logic [7:0] cur;
    evt_i = ev; sup_flt_i = sup; tmp_flt_i = tmp; rel_i = rel;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    cur = summ();
    if (rd) begin exp_rd = rd_val(a); last_addr = a; end
    for (int p = 0; p < 4; p++)
      m_ev[p] = ((rd && a == 5'(p + 2)) ? 6'b0 : m_ev[p]) | ev[p*6 +: 6];
    m_dev = ((rd && a == 5'h1D) ? 2'b00 : m_dev) | {tmp, sup};
    m_rel = (cur != 0) && (m_rel || rel);
    if (wr && a == 5'h01) m_mask = wd[5:0];
    @(posedge clk);
    @(negedge clk);
    chk(m_rel ? "R7" : "R1", {7'b0, int_n}, {7'b0, !(summ() != 0 && !m_rel)});
    chk(rd ? rd_tag(a) : "R9", reg_rdata, exp_rd);
  endtask

  task automatic idle();
    step('0, 0, 0, 0, 0, 0, 5'h00, 8'h00);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) m_ev[p] = '0;
    m_mask = '0; m_dev = '0; m_rel = 0; exp_rd = '0; last_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {7'b0, int_n}, 8'h01);
    chk("R10", reg_rdata, 8'h00);
    step('0, 0, 0, 0, 1, 0, 5'h01, 0);                   // R10 mask reset zero
    // R3/R2: masked-off event leaves summary clear, then unmasking raises it
    step(24'h1 << (2*6 + 3), 0, 0, 0, 0, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 5'h00, 0);
    step('0, 0, 0, 0, 0, 1, 5'h01, 8'hFF);              // R4 write, upper bits dropped
    step('0, 0, 0, 0, 1, 0, 5'h01, 0);
    step('0, 0, 0, 0, 1, 0, 5'h00, 0);                   // R2 expect 0x04
    // R7: release, then a new event must not re-raise
    step('0, 0, 0, 1, 0, 0, 0, 0);
    step(24'h1 << (1*6 + 0), 0, 0, 0, 0, 0, 0, 0);
    idle();
    step('0, 0, 0, 0, 1, 0, 5'h04, 0);                   // R5 port 2
    step('0, 0, 0, 0, 1, 0, 5'h03, 0);                   // R5 port 1
    idle(); idle();
    step(24'h1 << 5, 0, 0, 0, 0, 0, 0, 0);               // R7 new event asserts again
    // R6: event coinciding with the clearing read survives
    step(24'h1 << 2, 0, 0, 0, 1, 0, 5'h02, 0);
    step('0, 0, 0, 0, 1, 0, 5'h02, 0);
    // R9: write to a port register and an unmapped address is ignored
    step('0, 0, 0, 0, 0, 1, 5'h03, 8'h3F);
    step('0, 0, 0, 0, 0, 1, 5'h10, 8'h3F);
    step('0, 0, 0, 0, 1, 0, 5'h03, 0);
    step('0, 0, 0, 0, 1, 0, 5'h10, 0);
    // R8: device flags, unmasked
    step('0, 0, 0, 0, 0, 1, 5'h01, 8'h00);
    step('0, 0, 1, 0, 0, 0, 0, 0);
    step('0, 1, 0, 0, 1, 0, 5'h00, 0);
    step('0, 0, 0, 0, 1, 0, 5'h1D, 0);
    step('0, 0, 0, 0, 1, 0, 5'h1D, 0);
    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] ev;
      logic [4:0]  a;
      int sel;
      ev = '0;
      for (int b = 0; b < 24; b++) ev[b] = ($urandom % 24) == 0;
      sel = $urandom % 9;
      a = (sel < 6) ? 5'(sel) : (sel == 6) ? 5'h1D : 5'($urandom % 32);
      step(ev, ($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 8) == 0,
           ($urandom % 3) == 0, ($urandom % 8) == 0, a, 8'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule